// File: doc/BRIEF.md
# Precision-Time Event Frame Classifier

This block watches a receive byte stream, one byte per accepted cycle, and decides for every frame whether it carries a precision-time-protocol event message that the timestamp capture logic should keep. A frame matches in one of two ways. It can carry the precision-time EtherType 0x88F7 directly, at Layer 2. It can also be an IPv4/UDP datagram sent to event port 319, at Layer 4. In that case the UDP source port may also be required to equal 319. One optional 802.1Q tag is skipped, and IPv4 headers of any legal length are handled.

A mode input chooses how strict the filter is. The first mode takes version-1 messages over UDP only. The second takes version-2 messages over either transport. The third takes any version-2 event message. The fourth takes every frame. A one-bit selector chooses whether Sync or Delay_Req is accepted; only one of the two can be chosen at a time. A global enable gates the whole filter. After each frame ends, the block raises a single-cycle qualify pulse if the frame matched.

Top module: `ptp_evt_classifier`

## Requirements
- R1: While `cfgEnable` is 0 at the decision cycle, `qualify` stays 0 for every frame in every mode.
- R2: The qualify pulse lasts one cycle. It is high only in the cycle that follows the second rising edge after the frame's last byte (`inVld` and `inLast` both high) is sampled. After reset `qualify` is 0.
- R3: When `cfgMode` is 3 (all frames) and the block is enabled, every frame qualifies, including short and non-IP frames.
- R4: A Layer 2 match needs EtherType 0x88F7 at byte offsets 12 and 13, high byte first. The precision-time header then starts at offset 14.
- R5: A Layer 4 match needs all of the following. EtherType 0x0800. An IPv4 first byte whose version nibble (bits 7:4) is 4 and whose IHL (bits 3:0) is at least 5. The protocol byte at IP offset 9 equal to 17. A UDP destination port of 319 at UDP offsets 2 and 3. The UDP header starts at IP start + 4×IHL, and the precision-time header starts 8 bytes after it.
- R6: When `cfgSrcChk` is 1, a Layer 4 match also needs a UDP source port of 319 at UDP offsets 0 and 1. When it is 0, the source port is ignored.
- R7: In mode 1 (version 2, either transport), the version nibble (bits 3:0 of header byte 1) must be 2. The message type (bits 3:0 of header byte 0) must equal `cfgMsgSel`, where 0 is Sync and 1 is Delay_Req.
- R8: In mode 2 (any version-2 event), the version nibble must be 2 and the message type must be 0 to 3. `cfgMsgSel` is ignored.
- R9: In mode 0 (version 1), only Layer 4 frames match. The version nibble must be 1, and the control byte at header offset 32 must equal `cfgMsgSel` (0 Sync, 1 Delay_Req).
- R10: A frame that ends before every byte its mode inspects has arrived never qualifies, except in mode 3.
- R11: If the first EtherType is 0x8100, the four tag bytes are skipped. The real EtherType is then read at offsets 16 and 17, and all later offsets move by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inVld | input | 1 | Byte valid |
| inByte | input | 8 | Frame byte, destination address first |
| inLast | input | 1 | Marks the last byte of a frame |
| cfgEnable | input | 1 | Global receive-stamp enable |
| cfgMode | input | 2 | 0 v1 UDP, 1 v2 L2/UDP, 2 v2 any event, 3 all frames |
| cfgMsgSel | input | 1 | Accepted message: 0 Sync, 1 Delay_Req |
| cfgSrcChk | input | 1 | Also require UDP source port 319 |
| qualify | output | 1 | One-cycle pulse per matching frame |

## Verification
The verdict for a frame is due exactly two rising edges after its last byte is sampled. One edge sets the end marker and the next registers the decision. The configuration inputs are read at that second edge. The bench monitor records the last-byte flag at each rising edge and shifts it once more. At the falling edge where the shifted flag is set, it pops the next expected verdict from the scoreboard queue and compares it with `qualify`. At every other falling edge it treats a high `qualify` as a failure, so a pulse that comes early, comes late or repeats is caught as well as a wrong verdict.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [1:0] {
    MODE_V1_L4    = 2'd0,
    MODE_V2_L2L4  = 2'd1,
    MODE_V2_EVENT = 2'd2,
    MODE_ALL      = 2'd3
  } modeT;

  typedef struct packed {
    logic sof;
    logic capEtHi;
    logic capEtLo;
    logic etOuter;
    logic capIhl;
    logic capProto;
    logic capSrcHi;
    logic capSrcLo;
    logic capDstHi;
    logic capDstLo;
    logic capMsg;
    logic capVer;
    logic capCtl;
    logic frameEnd;
  } strobeT;

  localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
endpackage

// File: rtl/ptpc_ctrl.sv
module ptpc_ctrl
  import ptpc_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int ET_OFS   = 12,
  parameter int TAG_LEN  = 4,
  parameter int UDP_LEN  = 8,
  parameter int CTL_OFS  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inVld,
  input  logic       inLast,
  input  logic       vlanSeen,
  input  logic       isIp,
  input  logic       isL2,
  input  logic [3:0] ihl,
  output strobeT     strb
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] ET0      = CNT_W'(ET_OFS);
  localparam logic [CNT_W-1:0] ET1      = CNT_W'(ET_OFS + TAG_LEN);
  localparam logic [CNT_W-1:0] L3_PLAIN = CNT_W'(ET_OFS + 2);
  localparam logic [CNT_W-1:0] L3_TAG   = CNT_W'(ET_OFS + 2 + TAG_LEN);

  logic [CNT_W-1:0] byteCnt;
  logic             endPend;
  logic [CNT_W-1:0] l3Base, udpBase, ptpBase;
  logic             l4Ready, ptpReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
      endPend <= 1'b0;
    end else begin
      endPend <= inVld && inLast;
      if (inVld) begin
        if (inLast)                byteCnt <= '0;
        else if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  always_comb begin
    l3Base   = vlanSeen ? L3_TAG : L3_PLAIN;
    udpBase  = l3Base + (CNT_W'(ihl) << 2);
    ptpBase  = isIp ? udpBase + CNT_W'(UDP_LEN) : l3Base;
    l4Ready  = isIp && (ihl >= 4'd5) && (byteCnt > l3Base);
    ptpReady = isL2 || l4Ready;
  end

  always_comb begin
    strb          = '0;
    strb.sof      = inVld && (byteCnt == '0);
    strb.etOuter  = (byteCnt == ET0 + 1'b1);
    strb.capEtHi  = inVld && ((byteCnt == ET0) || (vlanSeen && byteCnt == ET1));
    strb.capEtLo  = inVld && ((byteCnt == ET0 + 1'b1) || (vlanSeen && byteCnt == ET1 + 1'b1));
    strb.capIhl   = inVld && isIp && (byteCnt == l3Base);
    strb.capProto = inVld && isIp && (byteCnt == l3Base + CNT_W'(9));
    strb.capSrcHi = inVld && l4Ready && (byteCnt == udpBase);
    strb.capSrcLo = inVld && l4Ready && (byteCnt == udpBase + CNT_W'(1));
    strb.capDstHi = inVld && l4Ready && (byteCnt == udpBase + CNT_W'(2));
    strb.capDstLo = inVld && l4Ready && (byteCnt == udpBase + CNT_W'(3));
    strb.capMsg   = inVld && ptpReady && (byteCnt == ptpBase);
    strb.capVer   = inVld && ptpReady && (byteCnt == ptpBase + CNT_W'(1));
    strb.capCtl   = inVld && ptpReady && (byteCnt == ptpBase + CNT_W'(CTL_OFS));
    strb.frameEnd = endPend;
  end
endmodule

// File: rtl/ptpc_dpath.sv
module ptpc_dpath
  import ptpc_pkg::*;
#(
  parameter int PORT_NUM = 319
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inByte,
  input  strobeT     strb,
  input  logic       cfgEnable,
  input  logic [1:0] cfgMode,
  input  logic       cfgMsgSel,
  input  logic       cfgSrcChk,
  output logic       vlanSeen,
  output logic       isIp,
  output logic       isL2,
  output logic [3:0] ihl,
  output logic       qualify
);
  localparam logic [15:0] PORT_VAL = 16'(PORT_NUM);

  logic [15:0] etype, srcPort, dstPort;
  logic [3:0]  ipVer, msgNib, verNib;
  logic [7:0]  proto, ctlByte;
  logic        gotEt, gotProto, gotSrc, gotDst, gotVer, gotCtl;
  logic        l2Ok, l4Ok, anyOk, match;
  modeT        mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      etype <= '0; srcPort <= '0; dstPort <= '0;
      ipVer <= '0; ihl <= '0; msgNib <= '0; verNib <= '0;
      proto <= '0; ctlByte <= '0; vlanSeen <= 1'b0;
      gotEt <= 1'b0; gotProto <= 1'b0; gotSrc <= 1'b0;
      gotDst <= 1'b0; gotVer <= 1'b0; gotCtl <= 1'b0;
    end else if (strb.sof) begin
      etype <= '0; ihl <= '0; vlanSeen <= 1'b0;
      gotEt <= 1'b0; gotProto <= 1'b0; gotSrc <= 1'b0;
      gotDst <= 1'b0; gotVer <= 1'b0; gotCtl <= 1'b0;
    end else begin
      if (strb.capEtHi) begin
        etype[15:8] <= inByte;
        gotEt       <= 1'b0;
      end
      if (strb.capEtLo) begin
        etype[7:0] <= inByte;
        gotEt      <= 1'b1;
        if (strb.etOuter && {etype[15:8], inByte} == ETYPE_VLAN) vlanSeen <= 1'b1;
      end
      if (strb.capIhl) begin
        ipVer <= inByte[7:4];
        ihl   <= inByte[3:0];
      end
      if (strb.capProto) begin
        proto    <= inByte;
        gotProto <= 1'b1;
      end
      if (strb.capSrcHi) srcPort[15:8] <= inByte;
      if (strb.capSrcLo) begin
        srcPort[7:0] <= inByte;
        gotSrc       <= 1'b1;
      end
      if (strb.capDstHi) dstPort[15:8] <= inByte;
      if (strb.capDstLo) begin
        dstPort[7:0] <= inByte;
        gotDst       <= 1'b1;
      end
      if (strb.capMsg) msgNib <= inByte[3:0];
      if (strb.capVer) begin
        verNib <= inByte[3:0];
        gotVer <= 1'b1;
      end
      if (strb.capCtl) begin
        ctlByte <= inByte;
        gotCtl  <= 1'b1;
      end
    end
  end

  always_comb begin
    isIp  = gotEt && (etype == ETYPE_IPV4);
    isL2  = gotEt && (etype == ETYPE_PTP);
    mode  = modeT'(cfgMode);
    l2Ok  = isL2;
    l4Ok  = isIp && (ipVer == 4'd4) && (ihl >= 4'd5) && gotProto && (proto == PROTO_UDP)
            && gotDst && (dstPort == PORT_VAL)
            && (!cfgSrcChk || (gotSrc && srcPort == PORT_VAL));
    anyOk = l2Ok || l4Ok;
    unique case (mode)
      MODE_V1_L4:    match = l4Ok && gotCtl && (verNib == 4'd1)
                             && (ctlByte == {7'd0, cfgMsgSel});
      MODE_V2_L2L4:  match = anyOk && gotVer && (verNib == 4'd2)
                             && (msgNib == {3'd0, cfgMsgSel});
      MODE_V2_EVENT: match = anyOk && gotVer && (verNib == 4'd2) && (msgNib <= 4'd3);
      default:       match = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) qualify <= 1'b0;
    else     qualify <= strb.frameEnd && cfgEnable && match;
  end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptpc_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int PORT_NUM = 319
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inVld,
  input  logic [7:0] inByte,
  input  logic       inLast,
  input  logic       cfgEnable,
  input  logic [1:0] cfgMode,
  input  logic       cfgMsgSel,
  input  logic       cfgSrcChk,
  output logic       qualify
);
  strobeT     strb;
  logic       vlanSeen, fbIsIp, fbIsL2;
  logic [3:0] fbIhl;

  ptpc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .inVld(inVld), .inLast(inLast),
    .vlanSeen(vlanSeen), .isIp(fbIsIp), .isL2(fbIsL2), .ihl(fbIhl),
    .strb(strb)
  );

  ptpc_dpath #(.PORT_NUM(PORT_NUM)) u_dp (
    .clk(clk), .rst(rst), .inByte(inByte), .strb(strb),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgMsgSel(cfgMsgSel),
    .cfgSrcChk(cfgSrcChk), .vlanSeen(vlanSeen), .isIp(fbIsIp),
    .isL2(fbIsL2), .ihl(fbIhl), .qualify(qualify)
  );
endmodule

// File: rtl/ptpc_chk.sv
module ptpc_chk
  import ptpc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       inVld,
  input logic       inLast,
  input logic       cfgEnable,
  input logic [1:0] cfgMode,
  input logic       qualify,
  input logic       fbIsIp,
  input strobeT     strb
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    qualify |-> $past(cfgEnable)); // R1

  AST_PULSE_TIMING: assert property (@(posedge clk) disable iff (rst)
    qualify |-> $past(inVld && inLast, 2)); // R2

  AST_ALL_MODE_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(inVld && inLast, 2) && $past(cfgEnable) && $past(cfgMode) == MODE_ALL) |-> qualify); // R3

  AST_V1_NEEDS_UDP: assert property (@(posedge clk) disable iff (rst)
    (qualify && $past(cfgMode) == MODE_V1_L4) |-> $past(fbIsIp)); // R9

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.sof, strb.capEtHi, strb.capEtLo, strb.capIhl, strb.capProto,
              strb.capSrcHi, strb.capSrcLo, strb.capDstHi, strb.capDstLo,
              strb.capMsg, strb.capVer, strb.capCtl})); // R11
endmodule

bind ptp_evt_classifier ptpc_chk u_chk (
  .clk(clk), .rst(rst), .inVld(inVld), .inLast(inLast), .cfgEnable(cfgEnable),
  .cfgMode(cfgMode), .qualify(qualify), .fbIsIp(fbIsIp), .strb(strb)
);

// File: tb/tb_ptp_evt_classifier.sv
module tb_ptp_evt_classifier;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inVld = 1'b0;
  logic [7:0] inByte = '0;
  logic       inLast = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic       cfgMsgSel = 1'b0;
  logic       cfgSrcChk = 1'b0;
  logic       qualify;

  int testsRun = 0;
  int testsFail = 0;
  bit expQ[$];
  string tagQ[$];
  logic [7:0] frm[$];
  logic p0 = 1'b0, p1 = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptp_evt_classifier dut (
    .clk(clk), .rst(rst), .inVld(inVld), .inByte(inByte), .inLast(inLast),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgMsgSel(cfgMsgSel),
    .cfgSrcChk(cfgSrcChk), .qualify(qualify)
  );

  always @(posedge clk) begin
    p0 <= inVld && inLast;
    p1 <= p0;
  end

  // monitor: verdict due two edges after the last byte
  always @(negedge clk) begin
    if (!rst) begin
      if (p1) begin
        bit e;
        string t;
        e = (expQ.size() > 0) ? expQ.pop_front() : 1'b0;
        t = (tagQ.size() > 0) ? tagQ.pop_front() : "R2";
        testsRun++;
        if (qualify !== e) begin
          testsFail++;
          $display("FAIL %s: qualify=%0b expected=%0b", t, qualify, e);
        end
      end else if (qualify !== 1'b0) begin
        testsFail++;
        $display("FAIL R2: stray pulse qualify=%0b expected=0", qualify);
      end
    end
  end

  // kind 0 = L2, 1 = IPv4/UDP, 2 = other EtherType
  task automatic mkFrame(input int kind, input bit vlan, input int ihl, input int proto,
                         input int sport, input int dport, input int ver, input int msg,
                         input int ctl, input int keep);
    frm.delete();
    for (int i = 0; i < 12; i++) frm.push_back(8'hA0 + 8'(i));
    if (vlan) begin
      frm.push_back(8'h81); frm.push_back(8'h00);
      frm.push_back(8'h00); frm.push_back(8'h05);
    end
    case (kind)
      0: begin frm.push_back(8'h88); frm.push_back(8'hF7); end
      1: begin frm.push_back(8'h08); frm.push_back(8'h00); end
      default: begin frm.push_back(8'h08); frm.push_back(8'h06); end
    endcase
    if (kind == 1) begin
      frm.push_back({4'h4, 4'(ihl)});
      for (int i = 1; i < ihl * 4; i++) frm.push_back((i == 9) ? 8'(proto) : 8'h00);
      frm.push_back(8'(sport >> 8)); frm.push_back(8'(sport));
      frm.push_back(8'(dport >> 8)); frm.push_back(8'(dport));
      for (int i = 0; i < 4; i++) frm.push_back(8'h00);
    end
    frm.push_back(8'(msg));
    frm.push_back(8'(ver));
    for (int i = 2; i < 44; i++) frm.push_back((i == 32) ? 8'(ctl) : 8'hEE);
    if (keep > 0) while (frm.size() > keep) void'(frm.pop_back());
  endtask

  task automatic sendFrame(input bit exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    foreach (frm[i]) begin
      @(negedge clk);
      inVld = 1'b1;
      inByte = frm[i];
      inLast = (i == frm.size() - 1);
    end
    @(negedge clk);
    inVld = 1'b0; inLast = 1'b0; inByte = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input bit en, input int mode, input bit sel, input bit src);
    @(negedge clk);
    cfgEnable = en; cfgMode = 2'(mode); cfgMsgSel = sel; cfgSrcChk = src;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testsRun++;
    if (qualify !== 1'b0) begin
      testsFail++;
      $display("FAIL R2: reset qualify=%0b expected=0", qualify);
    end
    rst = 1'b0;

    // R1: disabled, even in all-frames mode
    setCfg(0, 3, 0, 0);
    mkFrame(0, 0, 5, 17, 319, 319, 2, 0, 0, 0); sendFrame(0, "R1 disabled");
    // R3: all mode, short non-IP frame
    setCfg(1, 3, 0, 0);
    mkFrame(2, 0, 5, 17, 0, 0, 0, 0, 0, 20); sendFrame(1, "R3 all short");
    mkFrame(1, 0, 5, 6, 1, 2, 0, 9, 0, 0);  sendFrame(1, "R3 all tcp");
    // R4 R7: v2 mode, Sync
    setCfg(1, 1, 0, 0);
    mkFrame(0, 0, 5, 17, 319, 319, 2, 0, 0, 0); sendFrame(1, "R4 R7 L2 sync");
    mkFrame(0, 0, 5, 17, 319, 319, 2, 1, 0, 0); sendFrame(0, "R7 L2 dreq not sel");
    mkFrame(0, 0, 5, 17, 319, 319, 1, 0, 0, 0); sendFrame(0, "R7 version 1");
    mkFrame(2, 0, 5, 17, 319, 319, 2, 0, 0, 0); sendFrame(0, "R4 wrong etype");
    // R5 R11: v2 mode, Delay_Req over UDP
    setCfg(1, 1, 1, 0);
    mkFrame(1, 0, 5, 17, 1000, 319, 2, 1, 0, 0); sendFrame(1, "R5 udp dreq");
    mkFrame(1, 1, 5, 17, 1000, 319, 2, 1, 0, 0); sendFrame(1, "R11 vlan udp");
    mkFrame(0, 1, 5, 17, 0, 0, 2, 1, 0, 0);      sendFrame(1, "R11 vlan L2");
    mkFrame(1, 0, 5, 17, 319, 320, 2, 1, 0, 0);  sendFrame(0, "R5 port 320");
    mkFrame(1, 0, 5, 6, 319, 319, 2, 1, 0, 0);   sendFrame(0, "R5 proto tcp");
    mkFrame(1, 0, 7, 17, 319, 319, 2, 1, 0, 0);  sendFrame(1, "R5 ihl 7");
    // R6: source-port check
    setCfg(1, 1, 1, 1);
    mkFrame(1, 0, 5, 17, 319, 319, 2, 1, 0, 0);  sendFrame(1, "R6 src 319");
    mkFrame(1, 0, 5, 17, 1000, 319, 2, 1, 0, 0); sendFrame(0, "R6 src 1000");
    // R8: any v2 event
    setCfg(1, 2, 1, 0);
    mkFrame(1, 0, 5, 17, 1, 319, 2, 3, 0, 0); sendFrame(1, "R8 type 3");
    mkFrame(0, 0, 5, 17, 0, 0, 2, 2, 0, 0);   sendFrame(1, "R8 type 2 L2");
    mkFrame(0, 0, 5, 17, 0, 0, 2, 8, 0, 0);   sendFrame(0, "R8 type 8");
    // R9: version 1 over UDP
    setCfg(1, 0, 0, 0);
    mkFrame(1, 0, 5, 17, 1, 319, 1, 0, 0, 0); sendFrame(1, "R9 v1 sync");
    mkFrame(1, 0, 5, 17, 1, 319, 1, 0, 1, 0); sendFrame(0, "R9 v1 ctl dreq");
    mkFrame(0, 0, 5, 17, 0, 0, 1, 0, 0, 0);   sendFrame(0, "R9 v1 on L2");
    setCfg(1, 0, 1, 0);
    mkFrame(1, 0, 5, 17, 1, 319, 1, 0, 1, 0); sendFrame(1, "R9 v1 dreq");
    // R10: truncation (v1 control at byte 74, v2 version at byte 15)
    mkFrame(1, 0, 5, 17, 1, 319, 1, 0, 1, 74); sendFrame(0, "R10 v1 short");
    mkFrame(1, 0, 5, 17, 1, 319, 1, 0, 1, 75); sendFrame(1, "R10 v1 exact");
    setCfg(1, 1, 0, 0);
    mkFrame(0, 0, 5, 17, 0, 0, 2, 0, 0, 15); sendFrame(0, "R10 v2 short");
    mkFrame(0, 0, 5, 17, 0, 0, 2, 0, 0, 16); sendFrame(1, "R10 v2 exact");
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        testsRun++;
        testsFail++;
        $display("FAIL watchdog: run hung, done=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule